// File: doc/BRIEF.md
# Descriptor-Driven Multichannel DMA Engine

This block moves data between memory locations for up to `NUM_CH` independent channels, using a single shared transfer engine. Each channel's settings (source and destination pointers, element width, stepping flags, loop lengths, loop-boundary offsets and iteration counters) live in a per-channel descriptor store, not in per-channel registers. When a channel is granted, the engine loads its descriptor into one working register set and performs one minor loop of element copies. Each copy is a read cycle followed by a write cycle on a single memory port. The engine then writes the updated pointers and iteration count back to the store and releases the channel.

Software fills descriptors through a simple field write port. It starts a channel with a one-cycle start pulse, or it enables the channel's hardware request line. Minor loops nest inside a major loop. A signed offset is added to each pointer after every minor loop, and a separate one is added after the final minor loop, which makes circular buffers possible. The block pulses done outputs at minor-loop and major-loop completion, and it can hold a per-channel interrupt.

Top module: `desc_dma`

## Requirements
- R1: While `rstN` is low and after it rises with no request pending, `memRe`, `memWe`, `minorDone`, `majorDone` and every `irq` bit are 0.
- R2: Among the channels with a pending request, the lowest-numbered channel is granted. A granted channel completes its whole minor loop before any other channel is granted, even if a lower-numbered request arrives meanwhile.
- R3: A `cfgWe` cycle stores `cfgData` into field `cfgField` of channel `cfgCh`. Field 0 is the source pointer, field 1 the destination pointer, field 2 the minor-loop length in elements (at least 1), and field 3 the control word. Control bits 3:2 give the element size on `memSize`: 0 is one byte, 1 is two bytes, 2 is four bytes, and 3 acts as four bytes. Each element is one `memRe` cycle at the source pointer, then in the next cycle one `memWe` cycle at the destination pointer whose `memWdata` is the `memRdata` returned for that read. Data sits in the low byte lanes.
- R4: Control bit 0 makes the source pointer, and control bit 1 the destination pointer, advance by the element size in bytes after each element. When the bit is clear, that pointer stays constant within the minor loop.
- R5: After a minor loop that is not the last of its major loop, the signed offsets in field 4 (source) and field 5 (destination) are added to the pointers. After the last minor loop, the offsets in field 6 (source) and field 7 (destination) are added instead. Pointer arithmetic wraps modulo 2^`ADDR_W`.
- R6: Writing field 8 sets both the starting and the current major iteration count. Each minor loop decrements the current count. The minor loop run at a count of 1 or less is the last one. After it, the current count is reloaded from the starting count, and the next service begins a new major loop from the updated pointers.
- R7: A `swStart` pulse queues exactly one minor loop for that channel. A high `hwReq` line is serviced, one minor loop per grant, only while the channel's hardware enable (field 9, bit 0) is set. Completion of the major loop clears that enable.
- R8: `minorDone` is a one-cycle pulse at the end of every minor loop, with `doneCh` giving the channel. `majorDone` pulses in the same cycle only when that minor loop was the last of the major loop.
- R9: With control bit 4 set, completion of the major loop sets `irq[ch]`, which stays high until an `irqClr[ch]` pulse. With the bit clear, `irq[ch]` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Descriptor field write strobe |
| cfgCh | input | CH_W | Channel addressed by the field write |
| cfgField | input | 4 | Field code of the write |
| cfgData | input | ADDR_W | Field value |
| swStart | input | NUM_CH | Per-channel software start pulses |
| hwReq | input | NUM_CH | Per-channel hardware request lines |
| irqClr | input | NUM_CH | Per-channel interrupt clear pulses |
| memAddr | output | ADDR_W | Memory byte address |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memSize | output | 2 | Element size code of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after `memRe` |
| minorDone | output | 1 | Minor-loop completion pulse |
| majorDone | output | 1 | Major-loop completion pulse |
| doneCh | output | CH_W | Channel that just completed a loop |
| irq | output | NUM_CH | Sticky per-channel completion interrupts |

## Verification
The hardest state to reach is the boundary between major loops. There, the final-loop offsets replace the minor ones and the count reload must feed a further major loop that starts from the shifted pointers. The bench reaches it by issuing four software starts against a two-iteration descriptor, so that two major completions and a reload fall in one run. It sweeps every element size and stepping combination, comparing the whole memory image with an arithmetic replay. Arbitration ordering is exercised with a lower-numbered request that arrives while a longer minor loop is still running.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [3:0] {
    FLD_SRC     = 4'd0,
    FLD_DST     = 4'd1,
    FLD_MINOR   = 4'd2,
    FLD_CTRL    = 4'd3,
    FLD_MIN_SOF = 4'd4,
    FLD_MIN_DOF = 4'd5,
    FLD_MAJ_SOF = 4'd6,
    FLD_MAJ_DOF = 4'd7,
    FLD_ITER    = 4'd8,
    FLD_HWEN    = 4'd9
  } fieldE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RD,
    ST_WR,
    ST_WB
  } engStateE;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadDesc;
    logic issueRd;
    logic issueWr;
    logic closeMinor;
  } engStrobeT;

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobeT         strobe,
  input  logic [CH_W-1:0]   actCh,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [3:0]        cfgField,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  output logic [CNT_W-1:0]  minorLen,
  output logic              lastIter,
  output logic              intEn
);

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [CNT_W-1:0]  minorLen;
    logic [CNT_W-1:0]  curIter;
    logic [CNT_W-1:0]  startIter;
    logic [ADDR_W-1:0] minSOff;
    logic [ADDR_W-1:0] minDOff;
    logic [ADDR_W-1:0] majSOff;
    logic [ADDR_W-1:0] majDOff;
    logic              srcInc;
    logic              dstInc;
    logic [1:0]        size;
    logic              intEn;
  } descT;

  descT descRam [NUM_CH];
  descT work;

  logic [ADDR_W-1:0] stepBytes;
  logic [ADDR_W-1:0] srcStep, dstStep;
  logic [ADDR_W-1:0] nextSrc, nextDst;
  logic [CNT_W-1:0]  nextIter;

  always_comb begin
    case (work.size)
      2'd0:    stepBytes = ADDR_W'(1);
      2'd1:    stepBytes = ADDR_W'(2);
      default: stepBytes = ADDR_W'(4);
    endcase
  end

  assign srcStep  = work.srcInc ? stepBytes : '0;
  assign dstStep  = work.dstInc ? stepBytes : '0;
  assign lastIter = (work.curIter <= CNT_W'(1));
  assign nextSrc  = work.src + (lastIter ? work.majSOff : work.minSOff);
  assign nextDst  = work.dst + (lastIter ? work.majDOff : work.minDOff);
  assign nextIter = lastIter ? work.startIter : (work.curIter - CNT_W'(1));

  // Descriptor store: software field writes, engine writeback takes precedence
  always_ff @(posedge clk) begin
    if (cfgWe) begin
      case (fieldE'(cfgField))
        FLD_SRC:     descRam[cfgCh].src      <= cfgData;
        FLD_DST:     descRam[cfgCh].dst      <= cfgData;
        FLD_MINOR:   descRam[cfgCh].minorLen <= cfgData[CNT_W-1:0];
        FLD_CTRL: begin
          descRam[cfgCh].srcInc <= cfgData[0];
          descRam[cfgCh].dstInc <= cfgData[1];
          descRam[cfgCh].size   <= cfgData[3:2];
          descRam[cfgCh].intEn  <= cfgData[4];
        end
        FLD_MIN_SOF: descRam[cfgCh].minSOff  <= cfgData;
        FLD_MIN_DOF: descRam[cfgCh].minDOff  <= cfgData;
        FLD_MAJ_SOF: descRam[cfgCh].majSOff  <= cfgData;
        FLD_MAJ_DOF: descRam[cfgCh].majDOff  <= cfgData;
        FLD_ITER: begin
          descRam[cfgCh].startIter <= cfgData[CNT_W-1:0];
          descRam[cfgCh].curIter   <= cfgData[CNT_W-1:0];
        end
        default: ;
      endcase
    end
    if (strobe.closeMinor) begin
      descRam[actCh].src     <= nextSrc;
      descRam[actCh].dst     <= nextDst;
      descRam[actCh].curIter <= nextIter;
    end
  end

  // Working copy of the active descriptor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work <= '0;
    end else if (strobe.loadDesc) begin
      work <= descRam[actCh];
    end else if (strobe.issueWr) begin
      work.src <= work.src + srcStep;
      work.dst <= work.dst + dstStep;
    end
  end

  assign memRe    = strobe.issueRd;
  assign memWe    = strobe.issueWr;
  assign memAddr  = strobe.issueWr ? work.dst : work.src;
  assign memSize  = (work.size == 2'd3) ? 2'd2 : work.size;
  assign memWdata = memRdata;
  assign minorLen = work.minorLen;
  assign intEn    = work.intEn;

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> memWe); // R3
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R3

endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] swStart,
  input  logic [NUM_CH-1:0] hwReq,
  input  logic [NUM_CH-1:0] irqClr,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [3:0]        cfgField,
  input  logic              cfgBit,
  input  logic [CNT_W-1:0]  minorLen,
  input  logic              lastIter,
  input  logic              intEn,
  output engStrobeT         strobe,
  output logic [CH_W-1:0]   actCh,
  output logic              minorDone,
  output logic              majorDone,
  output logic [NUM_CH-1:0] irq
);

  engStateE          state;
  logic [CNT_W-1:0]  elemCnt;
  logic [NUM_CH-1:0] swPend, hwEn, pending;
  logic [NUM_CH-1:0] grantMask, actMask;
  logic [NUM_CH-1:0] hwEnNext, irqNext;
  logic [CH_W-1:0]   pickCh;
  logic              pickValid, lastElem, grantNow, hwEnWrite;

  assign pending = swPend | (hwReq & hwEn);

  // Fixed priority: lowest index wins
  always_comb begin
    pickCh    = '0;
    pickValid = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pickCh    = CH_W'(i);
        pickValid = 1'b1;
      end
    end
  end

  assign grantNow  = (state == ST_IDLE) && pickValid;
  assign grantMask = grantNow ? (NUM_CH'(1) << pickCh) : '0;
  assign actMask   = NUM_CH'(1) << actCh;
  assign lastElem  = (elemCnt == minorLen - CNT_W'(1));
  assign hwEnWrite = cfgWe && (fieldE'(cfgField) == FLD_HWEN);

  assign minorDone = (state == ST_WB);
  assign majorDone = (state == ST_WB) && lastIter;

  assign strobe.loadDesc   = (state == ST_LOAD);
  assign strobe.issueRd    = (state == ST_RD);
  assign strobe.issueWr    = (state == ST_WR);
  assign strobe.closeMinor = (state == ST_WB);

  always_comb begin
    hwEnNext = hwEn;
    if (majorDone) hwEnNext[actCh] = 1'b0;
    if (hwEnWrite) hwEnNext[cfgCh] = cfgBit;
  end

  assign irqNext = (irq & ~irqClr) | ((majorDone && intEn) ? actMask : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      actCh   <= '0;
      elemCnt <= '0;
      swPend  <= '0;
      hwEn    <= '0;
      irq     <= '0;
    end else begin
      swPend <= (swPend & ~grantMask) | swStart;
      hwEn   <= hwEnNext;
      irq    <= irqNext;
      case (state)
        ST_IDLE: if (pickValid) begin
          actCh <= pickCh;
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          elemCnt <= '0;
          state   <= ST_RD;
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          if (lastElem) begin
            state <= ST_WB;
          end else begin
            elemCnt <= elemCnt + CNT_W'(1);
            state   <= ST_RD;
          end
        end
        ST_WB:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_MAJOR_WITH_MINOR: assert property (@(posedge clk) disable iff (!rstN)
    majorDone |-> minorDone); // R8
  AST_IRQ_ONLY_ON_MAJOR: assert property (@(posedge clk) disable iff (!rstN)
    (|(irq & ~$past(irq))) |-> $past(majorDone && intEn)); // R9
  AST_HWEN_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (majorDone && !hwEnWrite) |=> !hwEn[$past(actCh)]); // R7

endmodule

// File: rtl/desc_dma.sv
module desc_dma
  import dma_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [3:0]        cfgField,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [NUM_CH-1:0] swStart,
  input  logic [NUM_CH-1:0] hwReq,
  input  logic [NUM_CH-1:0] irqClr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              minorDone,
  output logic              majorDone,
  output logic [CH_W-1:0]   doneCh,
  output logic [NUM_CH-1:0] irq
);

  engStrobeT        strobe;
  logic [CH_W-1:0]  actCh;
  logic [CNT_W-1:0] minorLen;
  logic             lastIter, intEn;

  dma_control #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .swStart(swStart), .hwReq(hwReq), .irqClr(irqClr),
    .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgField(cfgField), .cfgBit(cfgData[0]),
    .minorLen(minorLen), .lastIter(lastIter), .intEn(intEn),
    .strobe(strobe), .actCh(actCh),
    .minorDone(minorDone), .majorDone(majorDone), .irq(irq)
  );

  dma_datapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .actCh(actCh),
    .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgField(cfgField), .cfgData(cfgData),
    .memRdata(memRdata),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memSize(memSize),
    .memWdata(memWdata),
    .minorLen(minorLen), .lastIter(lastIter), .intEn(intEn)
  );

  assign doneCh = actCh;

endmodule

// File: tb/desc_dma_tb.sv
module desc_dma_tb;
  localparam int NUM_CH = 16;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int CH_W   = 4;

  logic              clk, rstN;
  logic              cfgWe;
  logic [CH_W-1:0]   cfgCh;
  logic [3:0]        cfgField;
  logic [ADDR_W-1:0] cfgData;
  logic [NUM_CH-1:0] swStart, hwReq, irqClr;
  logic [ADDR_W-1:0] memAddr;
  logic              memRe, memWe;
  logic [1:0]        memSize;
  logic [31:0]       memWdata, memRdata;
  logic              minorDone, majorDone;
  logic [CH_W-1:0]   doneCh;
  logic [NUM_CH-1:0] irq;

  desc_dma #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int minorCnt = 0, majorCnt = 0, sizeBad = 0;
  int seq [64];
  int expSize = 0;
  logic [7:0] mem [1024];
  logic [7:0] expMem [1024];
  logic [31:0] rdReg;

  assign memRdata = rdReg;

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  // Memory model: registered read, byte-lane write
  always @(posedge clk) begin
    if (memRe) begin
      rdReg <= '0;
      for (int k = 0; k < 4; k++)
        if (k < nbytes(int'(memSize))) rdReg[8*k +: 8] <= mem[(int'(memAddr) + k) % 1024];
    end
    if (memWe)
      for (int k = 0; k < 4; k++)
        if (k < nbytes(int'(memSize))) mem[(int'(memAddr) + k) % 1024] <= memWdata[8*k +: 8];
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (minorDone) begin
        seq[minorCnt % 64] = int'(doneCh);
        minorCnt++;
      end
      if (majorDone) majorCnt++;
      if (memRe && int'(memSize) != expSize) sizeBad++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int fld, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgCh = CH_W'(ch); cfgField = 4'(fld); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic startSw(input logic [NUM_CH-1:0] m);
    @(negedge clk); swStart = m;
    @(negedge clk); swStart = '0;
  endtask

  task automatic waitMinor(input int target);
    int n = 0;
    while (minorCnt < target && n < 1000) begin
      @(negedge clk); n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic initMem();
    for (int i = 0; i < 1024; i++) begin
      mem[i]    = 8'((i * 7 + 3) % 256);
      expMem[i] = 8'((i * 7 + 3) % 256);
    end
  endtask

  // Arithmetic replay state
  logic [15:0] mS, mD, minS, minD, majS, majD;
  int mIter, mStart, mMinor, mSz;
  bit mSInc, mDInc;

  task automatic modelMinor();
    int nb = nbytes(mSz);
    for (int e = 0; e < mMinor; e++) begin
      for (int k = 0; k < nb; k++)
        expMem[(int'(mD) + k) % 1024] = expMem[(int'(mS) + k) % 1024];
      if (mSInc) mS = mS + 16'(nb);
      if (mDInc) mD = mD + 16'(nb);
    end
    if (mIter <= 1) begin
      mS = mS + majS; mD = mD + majD; mIter = mStart;
    end else begin
      mS = mS + minS; mD = mD + minD; mIter--;
    end
  endtask

  initial begin
    int base, baseMaj, bad, ie;
    rstN = 1'b0; cfgWe = 1'b0; cfgCh = '0; cfgField = '0; cfgData = '0;
    swStart = '0; hwReq = '0; irqClr = '0;
    initMem();
    repeat (3) @(negedge clk);
    check("R1 memRe in reset", 32'(memRe), 0);
    check("R1 memWe in reset", 32'(memWe), 0);
    check("R1 irq in reset", 32'(irq), 0);
    check("R1 minorDone in reset", 32'(minorDone), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle after reset", 32'(memRe | memWe | majorDone), 0);

    // Sweep: element size x source stepping x destination stepping
    for (int sz = 0; sz < 3; sz++)
      for (int si = 0; si < 2; si++)
        for (int di = 0; di < 2; di++) begin
          ie = (sz + si) % 2;
          initMem();
          mS = 16'd32; mD = 16'd600; minS = 16'd5; minD = 16'd3;
          majS = -16'sd20; majD = 16'd40;
          mIter = 2; mStart = 2; mMinor = 3; mSz = sz;
          mSInc = si[0]; mDInc = di[0];
          expSize = sz;
          cfg(3, 0, mS); cfg(3, 1, mD); cfg(3, 2, 16'(mMinor));
          cfg(3, 3, 16'(si | (di << 1) | (sz << 2) | (ie << 4)));
          cfg(3, 4, minS); cfg(3, 5, minD); cfg(3, 6, majS); cfg(3, 7, majD);
          cfg(3, 8, 16'(mStart));
          base = minorCnt; baseMaj = majorCnt; sizeBad = 0;
          for (int s = 0; s < 4; s++) begin
            startSw(16'h0008);
            waitMinor(base + s + 1);
            modelMinor();
          end
          bad = 0;
          for (int i = 0; i < 1024; i++) if (mem[i] !== expMem[i]) bad++;
          check($sformatf("R3 R4 R5 memory image sz=%0d si=%0d di=%0d", sz, si, di), 32'(bad), 0);
          check("R3 memSize code", 32'(sizeBad), 0);
          check("R8 minor pulses", 32'(minorCnt - base), 4);
          check("R6 major completions across reload", 32'(majorCnt - baseMaj), 2);
          check("R9 irq follows enable", 32'(irq[3]), 32'(ie));
          @(negedge clk); irqClr = 16'h0008;
          @(negedge clk); irqClr = '0;
          @(negedge clk);
          check("R9 irq cleared", 32'(irq[3]), 0);
        end

    // Arbitration: 2 and 5 together, 0 arrives while 2 is running
    expSize = 0;
    cfg(2, 0, 16'd10);  cfg(2, 1, 16'd520); cfg(2, 2, 16'd4); cfg(2, 3, 16'h3); cfg(2, 8, 16'd5);
    cfg(5, 0, 16'd20);  cfg(5, 1, 16'd540); cfg(5, 2, 16'd1); cfg(5, 3, 16'h3); cfg(5, 8, 16'd5);
    cfg(0, 0, 16'd30);  cfg(0, 1, 16'd560); cfg(0, 2, 16'd1); cfg(0, 3, 16'h3); cfg(0, 8, 16'd5);
    base = minorCnt; baseMaj = majorCnt;
    startSw(16'h0024);
    repeat (3) @(negedge clk);
    startSw(16'h0001);
    waitMinor(base + 3);
    check("R2 first grant", 32'(seq[base % 64]), 2);
    check("R2 late low channel waits for minor loop", 32'(seq[(base + 1) % 64]), 0);
    check("R2 last grant", 32'(seq[(base + 2) % 64]), 5);
    check("R8 no major before count expires", 32'(majorCnt - baseMaj), 0);

    // Hardware request gating and enable clearing
    cfg(4, 0, 16'd100); cfg(4, 1, 16'd800); cfg(4, 2, 16'd2); cfg(4, 3, 16'h13);
    cfg(4, 4, 16'd0); cfg(4, 5, 16'd0); cfg(4, 6, 16'd0); cfg(4, 7, 16'd0); cfg(4, 8, 16'd3);
    base = minorCnt; baseMaj = majorCnt;
    @(negedge clk); hwReq = 16'h0010;
    repeat (30) @(negedge clk);
    check("R7 request ignored while disabled", 32'(minorCnt - base), 0);
    cfg(4, 9, 16'd1);
    waitMinor(base + 3);
    repeat (40) @(negedge clk);
    check("R7 enable cleared after major loop", 32'(minorCnt - base), 3);
    check("R8 one major completion", 32'(majorCnt - baseMaj), 1);
    check("R9 irq set for enabled channel", 32'(irq[4]), 1);
    @(negedge clk); irqClr = 16'h0010;
    @(negedge clk); irqClr = '0; hwReq = '0;
    @(negedge clk);
    check("R9 irq cleared on hw channel", 32'(irq[4]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule